// File: doc/BRIEF.md
# Partitioned Serial FIR Filter

This block computes a direct-form FIR filter over `NTAPS` taps with a small, fixed number of multipliers. The taps are split into consecutive groups, each with a group size set by a parameter list. Each group owns one multiplier, one accumulator and a multiplexer that selects its own taps. When a sample strobe arrives, every group starts at once. All groups follow one shared step counter and add one product per clock until their own tap count is used up. The largest group therefore sets how many clocks one sample costs.

A parameter picks how the group results are merged. In tree mode, a combinational sum of all accumulators feeds the output register. In cascade mode, every group except the last adds the finished total of the group after it into its own accumulator, in the step right after its own products end. The first group then holds the whole result and no final adders are needed, at the price of one extra clock per sample. Cascade mode needs group sizes that fall strictly from the first group to the last, except that the last two may be equal. An invalid size list, or one whose sum differs from `NTAPS`, stops elaboration.

Samples are signed two's complement. The coefficients come in on a flat port and must be held steady while a sample is being processed. The result keeps full precision.

Top module: `fir_part_serial`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is 0, and every stored sample is zero.
- R2: For each accepted sample, `out_data` equals the sum over k from 0 to NTAPS-1 of c[k]*x[k]. Here c[k] is the signed value at `coef_i[k*COEF_W +: COEF_W]`, x[0] is the newest accepted sample, x[k] is the sample accepted k strobes earlier, and samples before reset count as zero.
- R3: In tree mode, `out_valid` rises on the clock edge that comes L+1 edges after the edge that accepted the sample, where L is the largest group size.
- R4: In cascade mode, the same delay is L+2 edges.
- R5: `out_valid` is high for exactly one cycle per accepted sample, and `out_data` holds its value between pulses.
- R6: A strobe that arrives while a sample is in progress is ignored, unless it arrives on the edge that produces the output. An ignored sample never enters the delay line and produces no `out_valid`.
- R7: A strobe on the output edge is accepted. Samples can therefore be taken every L+1 clocks in tree mode and every L+2 clocks in cascade mode.
- R8: With every sample at -2^(DATA_W-1) and every coefficient at -2^(COEF_W-1), the full sum is produced without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W | Signed input sample |
| coef_i | input | NTAPS*COEF_W | Signed coefficients, tap k in field k |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | DATA_W+COEF_W+clog2(NTAPS) | Signed filtered sample |

## Verification
A wrong step count or a misaligned group window changes which tap products are added, so the first result after the fault differs from the computed sum. A broken cascade link drops or repeats a whole group's partial sum in that same result. A wrong step limit moves `out_valid` by whole cycles, so the latency check fails on the first sample. A delay line that shifts on an ignored strobe leaves every later result off by one tap. Sweeps at the minimum spacing, at wider spacing, with an impulse and at the extreme values expose each of these within one sample period.

// File: rtl/fir_part_pkg.sv
package fir_part_pkg;

    localparam int MAX_PART = 16;
    localparam int SZ_W     = 8;
    localparam int STEP_W   = SZ_W + 1;

    typedef logic [MAX_PART*SZ_W-1:0] size_list_t;

    typedef enum logic {
        COMBINE_TREE    = 1'b0,
        COMBINE_CASCADE = 1'b1
    } combine_e;

    typedef struct packed {
        logic              run;
        logic [STEP_W-1:0] step;
    } seq_t;

    function automatic int size_of(size_list_t l, int i);
        return int'(l[i*SZ_W +: SZ_W]);
    endfunction

    function automatic int start_of(size_list_t l, int i);
        int s = 0;
        for (int j = 0; j < i; j++) s += size_of(l, j);
        return s;
    endfunction

    function automatic int total_of(size_list_t l, int n);
        return start_of(l, n);
    endfunction

    function automatic int largest_of(size_list_t l, int n);
        int m = 0;
        for (int j = 0; j < n; j++)
            if (size_of(l, j) > m) m = size_of(l, j);
        return m;
    endfunction

    function automatic bit sizes_nonzero(size_list_t l, int n);
        for (int j = 0; j < n; j++)
            if (size_of(l, j) == 0) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit cascade_legal(size_list_t l, int n);
        for (int j = 0; j < n - 1; j++) begin
            if (j < n - 2) begin
                if (size_of(l, j) <= size_of(l, j + 1)) return 1'b0;
            end else begin
                if (size_of(l, j) < size_of(l, j + 1)) return 1'b0;
            end
        end
        return 1'b1;
    endfunction

endpackage

// File: rtl/fir_seq.sv
module fir_seq
    import fir_part_pkg::*;
#(
    parameter int LAST_STEP = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic accept_o,
    output logic last_o,
    output seq_t seq_o
);

    localparam logic [STEP_W-1:0] LAST_S = STEP_W'(LAST_STEP);

    seq_t seq_q;

    assign last_o   = seq_q.run && (seq_q.step == LAST_S);
    assign accept_o = strobe_i && (!seq_q.run || last_o);
    assign seq_o    = seq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
        end else if (accept_o) begin
            seq_q.run  <= 1'b1;
            seq_q.step <= '0;
        end else if (last_o) begin
            seq_q.run <= 1'b0;
        end else if (seq_q.run) begin
            seq_q.step <= seq_q.step + STEP_W'(1);
        end
    end

    // R7: an accepted strobe always restarts the walk at step zero
    a_r7_start_at_zero: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> (seq_q.run && seq_q.step == '0));

    // R3 / R4: the walk advances one step per clock until the limit
    a_r3_step_advance: assert property (@(posedge clk) disable iff (rst)
        (seq_q.run && !last_o) |=> (seq_q.run && seq_q.step == $past(seq_q.step) + STEP_W'(1)));

endmodule

// File: rtl/fir_delay.sv
module fir_delay #(
    parameter int DATA_W = 8,
    parameter int NTAPS  = 11
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    shift_i,
    input  logic [DATA_W-1:0]       din_i,
    output logic [NTAPS*DATA_W-1:0] taps_o
);

    logic [DATA_W-1:0] stage [NTAPS];

    for (genvar k = 0; k < NTAPS; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage[k] <= '0;
            end else if (shift_i) begin
                if (k == 0) stage[k] <= din_i;
                else        stage[k] <= stage[(k == 0) ? 0 : k-1];
            end
        end
        assign taps_o[k*DATA_W +: DATA_W] = stage[k];
    end

endmodule

// File: rtl/fir_partition.sv
module fir_partition
    import fir_part_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int COEF_W    = 6,
    parameter int ACC_W     = 18,
    parameter int SIZE      = 4,
    parameter bit HAS_CHAIN = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear_i,
    input  seq_t                    seq_i,
    input  logic [SIZE*DATA_W-1:0]  taps_i,
    input  logic [SIZE*COEF_W-1:0]  coefs_i,
    input  logic signed [ACC_W-1:0] chain_i,
    output logic signed [ACC_W-1:0] acc_o
);

    localparam int PROD_W = DATA_W + COEF_W;
    localparam logic [STEP_W-1:0] SIZE_S = STEP_W'(SIZE);

    logic signed [DATA_W-1:0] sel_d;
    logic signed [COEF_W-1:0] sel_c;
    logic signed [PROD_W-1:0] prod;
    logic                     mac_en;
    logic                     chain_en;

    always_comb begin
        sel_d = '0;
        sel_c = '0;
        for (int i = 0; i < SIZE; i++) begin
            if (seq_i.step == STEP_W'(i)) begin
                sel_d = taps_i[i*DATA_W +: DATA_W];
                sel_c = coefs_i[i*COEF_W +: COEF_W];
            end
        end
    end

    assign prod     = sel_d * sel_c;
    assign mac_en   = seq_i.run && (seq_i.step < SIZE_S);
    assign chain_en = HAS_CHAIN && seq_i.run && (seq_i.step == SIZE_S);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            acc_o <= '0;
        end else if (mac_en) begin
            acc_o <= acc_o + ACC_W'(prod);
        end else if (chain_en) begin
            acc_o <= acc_o + chain_i;
        end
    end

endmodule

// File: rtl/fir_part_serial.sv
module fir_part_serial
    import fir_part_pkg::*;
#(
    parameter int       DATA_W     = 8,
    parameter int       COEF_W     = 6,
    parameter int       NTAPS      = 11,
    parameter int       NUM_PART   = 4,
    parameter logic [NUM_PART*SZ_W-1:0] PART_SIZES = {8'd2, 8'd2, 8'd3, 8'd4},
    parameter combine_e COMBINE    = COMBINE_CASCADE
) (
    input  logic                                             clk,
    input  logic                                             rst,
    input  logic                                             in_valid,
    input  logic [DATA_W-1:0]                                in_data,
    input  logic [NTAPS*COEF_W-1:0]                          coef_i,
    output logic                                             out_valid,
    output logic [DATA_W+COEF_W+$clog2(NTAPS)-1:0]           out_data
);

    localparam int         ACC_W   = DATA_W + COEF_W + $clog2(NTAPS);
    localparam size_list_t SIZES_L = size_list_t'(PART_SIZES);
    localparam int         L       = largest_of(SIZES_L, NUM_PART);
    localparam bit         CASC    = (COMBINE == COMBINE_CASCADE);
    localparam int         LAST    = CASC ? L + 1 : L;
    localparam bit         CFG_OK  = (NUM_PART <= MAX_PART)
                                  && (NUM_PART >= 1)
                                  && sizes_nonzero(SIZES_L, NUM_PART)
                                  && (total_of(SIZES_L, NUM_PART) == NTAPS)
                                  && (L < (1 << SZ_W) - 1)
                                  && (!CASC || cascade_legal(SIZES_L, NUM_PART));

    if (!CFG_OK) begin : g_cfg_bad
        initial $fatal(1, "fir_part_serial: illegal partition size list");
    end

    logic                    accept;
    logic                    last;
    seq_t                    seq;
    logic [NTAPS*DATA_W-1:0] taps;
    logic signed [ACC_W-1:0] acc [NUM_PART];
    logic signed [ACC_W-1:0] result;

    fir_seq #(.LAST_STEP(LAST)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (in_valid),
        .accept_o (accept),
        .last_o   (last),
        .seq_o    (seq)
    );

    fir_delay #(.DATA_W(DATA_W), .NTAPS(NTAPS)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .shift_i (accept),
        .din_i   (in_data),
        .taps_o  (taps)
    );

    for (genvar p = 0; p < NUM_PART; p++) begin : g_part
        localparam int START = start_of(SIZES_L, p);
        localparam int SIZE  = size_of(SIZES_L, p);
        localparam bit CHAIN = CASC && (p < NUM_PART - 1);

        logic signed [ACC_W-1:0] chain_in;
        if (p < NUM_PART - 1) begin : g_link
            assign chain_in = acc[(p < NUM_PART - 1) ? p + 1 : p];
        end else begin : g_end
            assign chain_in = '0;
        end

        fir_partition #(
            .DATA_W    (DATA_W),
            .COEF_W    (COEF_W),
            .ACC_W     (ACC_W),
            .SIZE      (SIZE),
            .HAS_CHAIN (CHAIN)
        ) u_part (
            .clk     (clk),
            .rst     (rst),
            .clear_i (accept),
            .seq_i   (seq),
            .taps_i  (taps[START*DATA_W +: SIZE*DATA_W]),
            .coefs_i (coef_i[START*COEF_W +: SIZE*COEF_W]),
            .chain_i (chain_in),
            .acc_o   (acc[p])
        );
    end

    if (CASC) begin : g_cascade_out
        assign result = acc[0];
    end else begin : g_tree_out
        always_comb begin
            result = '0;
            for (int p = 0; p < NUM_PART; p++) result = result + acc[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= last;
            if (last) out_data <= result;
        end
    end

    // R5: result strobe lasts a single cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R5: a result is only produced by a walk that was running
    a_r5_valid_from_run: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(seq.run));

    // R6: a strobe during a walk, off the final step, leaves the samples alone
    a_r6_ignored_strobe: assert property (@(posedge clk) disable iff (rst)
        (in_valid && seq.run && !last) |=> $stable(taps));

    // R5: output data holds between pulses
    a_r5_data_hold: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data) || $past(rst));

endmodule

// File: tb/test_fir_part_serial.sv
module test_fir_part_serial;
    import fir_part_pkg::*;

    localparam int DATA_W = 8;
    localparam int COEF_W = 6;
    localparam int NTAPS  = 11;
    localparam int ACC_W  = DATA_W + COEF_W + $clog2(NTAPS);
    localparam int CYC [2] = '{5, 6};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic                      iv [2];
    logic [DATA_W-1:0]         idat [2];
    logic [NTAPS*COEF_W-1:0]   coef_flat;
    logic                      ov [2];
    logic [ACC_W-1:0]          odat [2];

    int coef [NTAPS];
    int hist [2][NTAPS];
    int exp_val [2][256];
    int exp_edge [2][256];
    string exp_tag [2][256];
    int head [2];
    int tail [2];
    int ok_edge [2];
    int last_out [2];
    int ec = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always_comb begin
        for (int k = 0; k < NTAPS; k++) coef_flat[k*COEF_W +: COEF_W] = COEF_W'(coef[k]);
    end

    fir_part_serial #(
        .DATA_W(DATA_W), .COEF_W(COEF_W), .NTAPS(NTAPS), .NUM_PART(4),
        .PART_SIZES({8'd2, 8'd3, 8'd4, 8'd2}), .COMBINE(COMBINE_TREE)
    ) i_fir_part_serial_tree (
        .clk(clk), .rst(rst), .in_valid(iv[0]), .in_data(idat[0]),
        .coef_i(coef_flat), .out_valid(ov[0]), .out_data(odat[0])
    );

    fir_part_serial #(
        .DATA_W(DATA_W), .COEF_W(COEF_W), .NTAPS(NTAPS), .NUM_PART(4),
        .PART_SIZES({8'd2, 8'd2, 8'd3, 8'd4}), .COMBINE(COMBINE_CASCADE)
    ) i_fir_part_serial (
        .clk(clk), .rst(rst), .in_valid(iv[1]), .in_data(idat[1]),
        .coef_i(coef_flat), .out_valid(ov[1]), .out_data(odat[1])
    );

    always @(posedge clk) ec <= ec + 1;

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int expected_sum(int m);
        int s = 0;
        for (int k = 0; k < NTAPS; k++) s += coef[k] * hist[m][k];
        return s;
    endfunction

    // monitor: latency, data, single pulse, hold
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int m = 0; m < 2; m++) begin
                int act;
                act = int'($signed(odat[m]));
                if (head[m] < tail[m] && exp_edge[m][head[m]] < ec) begin
                    check(1'b0, {exp_tag[m][head[m]], " missing out_valid"}, 0, 1);
                    head[m]++;
                end
                if (head[m] < tail[m] && exp_edge[m][head[m]] == ec) begin
                    check(ov[m] === 1'b1, (m == 0) ? "R3 tree latency" : "R4 cascade latency",
                          int'(ov[m]), 1);
                    check(act == exp_val[m][head[m]], {exp_tag[m][head[m]], " out_data"},
                          act, exp_val[m][head[m]]);
                    last_out[m] = exp_val[m][head[m]];
                    head[m]++;
                end else if (ov[m] === 1'b1) begin
                    check(1'b0, "R5 R6 unexpected out_valid", 1, 0);
                end else begin
                    check(act == last_out[m], "R5 out_data hold", act, last_out[m]);
                end
            end
        end
    end

    task automatic strobe(int m, int val, int gap, string tag);
        if (gap > 1) repeat (gap - 1) @(posedge clk);
        @(negedge clk);
        iv[m]   = 1'b1;
        idat[m] = DATA_W'(val);
        @(posedge clk);
        #1;
        if (ec >= ok_edge[m]) begin
            for (int k = NTAPS - 1; k > 0; k--) hist[m][k] = hist[m][k-1];
            hist[m][0] = val;
            exp_val[m][tail[m]]  = expected_sum(m);
            exp_edge[m][tail[m]] = ec + CYC[m];
            exp_tag[m][tail[m]]  = tag;
            tail[m]++;
            ok_edge[m] = ec + CYC[m];
        end
        iv[m] = 1'b0;
    endtask

    task automatic settle(int m);
        repeat (CYC[m] + 3) @(posedge clk);
    endtask

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        for (int m = 0; m < 2; m++) begin
            iv[m] = 1'b0; idat[m] = '0; head[m] = 0; tail[m] = 0;
            ok_edge[m] = 0; last_out[m] = 0;
            for (int k = 0; k < NTAPS; k++) hist[m][k] = 0;
        end
        for (int k = 0; k < NTAPS; k++) coef[k] = ((k * 13 + 5) % 64) - 32;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int m = 0; m < 2; m++) begin
            check(ov[m] === 1'b0, "R1 reset out_valid", int'(ov[m]), 0);
            check(odat[m] === '0, "R1 reset out_data", int'($signed(odat[m])), 0);
        end

        for (int m = 0; m < 2; m++) begin
            // R1: first result only sees zeros in older taps
            strobe(m, 1, 1, "R1");
            // R2: impulse walks through every coefficient
            for (int i = 0; i < NTAPS; i++) strobe(m, 0, CYC[m] + 2, "R2");
            // R7: back-to-back at the minimum spacing
            for (int i = 0; i < 40; i++) strobe(m, ((i * 37 + 11) % 256) - 128, CYC[m], "R7");
            // R2: wider spacing
            for (int i = 0; i < 15; i++) strobe(m, ((i * 91 + 7) % 256) - 128, CYC[m] + 3, "R2");
            // R6: strobes inside a walk are dropped
            for (int i = 0; i < 6; i++) begin
                strobe(m, 60 - i * 17, CYC[m], "R6");
                strobe(m, 99, 2, "R6");
                strobe(m, -77, 2, "R6");
            end
            settle(m);
        end

        // R8: extreme negative samples and coefficients
        for (int k = 0; k < NTAPS; k++) coef[k] = -32;
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < NTAPS + 2; i++) strobe(m, -128, CYC[m], "R8");
            settle(m);
        end
        for (int k = 0; k < NTAPS; k++) coef[k] = 31;
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < NTAPS + 2; i++) strobe(m, (i % 2 == 0) ? 127 : -128, CYC[m], "R8");
            settle(m);
        end
        repeat (10) @(posedge clk);
        for (int m = 0; m < 2; m++)
            check(head[m] == tail[m], "R5 all results delivered", head[m], tail[m]);
        summary();
    end

endmodule